// File: doc/BRIEF.md
# Packed SIMD Shift Unit

This unit shifts a 64-bit operand treated as a vector of equal-width lanes: four 16-bit lanes, two 32-bit lanes or one 64-bit lane. It offers three operations: logical left, logical right and arithmetic right. One shift count applies to every lane. Bits never move from one lane into its neighbour, except when the whole word forms a single lane.

The count comes from one of two places. The first is a 64-bit count operand, compared as a full unsigned number. The second is an 8-bit immediate, zero-extended to 64 bits. A count at or above the lane width gives a defined result and does not wrap: zero for the logical shifts, and copies of each lane's sign bit for the arithmetic shift.

An arithmetic shift on the 64-bit lane is rejected, and so is any reserved encoding. In both cases a flag is raised and the operand passes through unchanged. The datapath is combinational. By default a single output register sits behind it, so a result appears one clock after its inputs.

Top module: `pk_shift_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `result_o` becomes zero and `illegal_o` becomes low; with the default `OUT_REG=1`, the outputs reflect the inputs sampled at the previous rising edge.
- R2: Logical left (`op_i`=2'b00) shifts each lane toward its most significant bit and fills the vacated low bits with zero.
- R3: Logical right (`op_i`=2'b01) shifts each lane toward its least significant bit and fills the vacated high bits with zero.
- R4: For a logical shift, a count above 15 (word lanes), above 31 (doubleword lanes) or above 63 (quadword lane) makes the whole result zero.
- R5: Arithmetic right (`op_i`=2'b10) fills the vacated high bits of each lane with that lane's original sign bit.
- R6: For an arithmetic shift, a count above 15 (word lanes) or above 31 (doubleword lanes) makes every lane all copies of its own sign bit.
- R7: The count operand is compared as a full unsigned 64-bit value, so any set bit above the low field forces the over-range result.
- R8: When `use_imm_i` is 1, the count is `imm_i` zero-extended to 64 bits and `count_i` has no effect (an immediate of 200 zeroes a logical result).
- R9: The lane-size encoding in `size_i` is 2'b00 for four 16-bit lanes at bits [16k+15:16k], 2'b01 for two 32-bit lanes, and 2'b10 for one 64-bit lane.
- R10: An arithmetic shift with `size_i`=2'b10, `op_i`=2'b11 or `size_i`=2'b11 sets `illegal_o` and passes `data_i` through unchanged to `result_o`.
- R11: A count of zero returns the operand unchanged for every legal operation and lane size.
- R12: In the 64-bit lane mode, bits cross the 16- and 32-bit boundaries as in one wide shift. In the narrower modes, no bit crosses a lane boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| data_i | input | 64 | Operand to be shifted |
| count_i | input | 64 | Count operand, full unsigned value |
| imm_i | input | 8 | Immediate count |
| use_imm_i | input | 1 | 1 selects the immediate as count |
| op_i | input | 2 | Operation: 00 left, 01 logical right, 10 arithmetic right |
| size_i | input | 2 | Lane size: 00 16-bit, 01 32-bit, 10 64-bit |
| result_o | output | 64 | Shifted result |
| illegal_o | output | 1 | Rejected operation/size combination |

## Verification
The hardest cases to reach are counts that look small in their low bits but are huge as 64-bit numbers. One such count is 2^32+1. A design that looks only at the low count field would shift by one, whereas the correct result is zero or sign fill. The stimulus places such counts on `count_i` directly. It also sends an immediate of 200 while `count_i` carries a small value, which separates the two count paths. Lane-crossing faults show up only when a lane's top or bottom bits are set, so the operands carry set bits at every lane boundary, and random operands and counts fill out the rest.

// File: rtl/pk_shift_pkg.sv
package pk_shift_pkg;

    localparam int PK_DATA_W = 64;
    localparam int PK_IMM_W  = 8;

    typedef logic [PK_DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        OP_SLL = 2'b00,
        OP_SRL = 2'b01,
        OP_SRA = 2'b10,
        OP_RSV = 2'b11
    } shift_op_e;

    typedef enum logic [1:0] {
        SZ_W16 = 2'b00,
        SZ_W32 = 2'b01,
        SZ_W64 = 2'b10,
        SZ_RSV = 2'b11
    } lane_sz_e;

    typedef struct packed {
        word_t data;
        word_t count;
        shift_op_e op;
        lane_sz_e  size;
    } shift_req_t;

    typedef struct packed {
        word_t result;
        logic  illegal;
    } shift_rsp_t;

    function automatic logic is_legal(input shift_op_e op, input lane_sz_e size);
        logic ok;
        ok = (op != OP_RSV) && (size != SZ_RSV);
        if (op == OP_SRA && size == SZ_W64) ok = 1'b0;
        return ok;
    endfunction

endpackage

// File: rtl/pk_count_sel.sv
module pk_count_sel
    import pk_shift_pkg::*;
#(
    parameter int DATA_W = PK_DATA_W,
    parameter int IMM_W  = PK_IMM_W
) (
    input  logic [DATA_W-1:0] count_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              use_imm_i,
    output logic [DATA_W-1:0] eff_count_o
);
    localparam int PAD_W = DATA_W - IMM_W;

    assign eff_count_o = use_imm_i ? {{PAD_W{1'b0}}, imm_i} : count_i;

endmodule

// File: rtl/pk_lane_shift.sv
module pk_lane_shift
    import pk_shift_pkg::*;
#(
    parameter int DATA_W = PK_DATA_W,
    parameter int LANE_W = 16
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] count_i,
    input  shift_op_e         op_i,
    output logic [DATA_W-1:0] res_o
);
    localparam int NLANE = DATA_W / LANE_W;
    localparam int SH_W  = $clog2(LANE_W);

    logic            over;
    logic [SH_W-1:0] amt;

    // Any count bit at or above the lane-width field puts the shift out of range.
    assign over = |count_i[DATA_W-1:SH_W];
    assign amt  = count_i[SH_W-1:0];

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic [LANE_W-1:0] seg, sll_v, srl_v, sra_v;
        assign seg   = data_i[g*LANE_W +: LANE_W];
        assign sll_v = over ? '0 : (seg << amt);
        assign srl_v = over ? '0 : (seg >> amt);
        assign sra_v = over ? {LANE_W{seg[LANE_W-1]}} : LANE_W'($signed(seg) >>> amt);
        assign res_o[g*LANE_W +: LANE_W] = (op_i == OP_SLL) ? sll_v :
                                           (op_i == OP_SRL) ? srl_v : sra_v;
    end

endmodule

// File: rtl/pk_shift_select.sv
module pk_shift_select
    import pk_shift_pkg::*;
#(
    parameter int DATA_W = PK_DATA_W
) (
    input  shift_req_t        req_i,
    input  logic [DATA_W-1:0] r16_i,
    input  logic [DATA_W-1:0] r32_i,
    input  logic [DATA_W-1:0] r64_i,
    output shift_rsp_t        rsp_o
);
    logic              legal;
    logic [DATA_W-1:0] sel;

    always_comb begin
        legal = is_legal(req_i.op, req_i.size);
        unique case (req_i.size)
            SZ_W16:  sel = r16_i;
            SZ_W32:  sel = r32_i;
            default: sel = r64_i;
        endcase
        rsp_o.result  = legal ? sel : req_i.data;
        rsp_o.illegal = !legal;
    end

endmodule

// File: rtl/pk_shift_unit.sv
module pk_shift_unit
    import pk_shift_pkg::*;
#(
    parameter int DATA_W  = PK_DATA_W,
    parameter int IMM_W   = PK_IMM_W,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] count_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              use_imm_i,
    input  logic [1:0]        op_i,
    input  logic [1:0]        size_i,
    output logic [DATA_W-1:0] result_o,
    output logic              illegal_o
);
    localparam int W16 = 16;
    localparam int W32 = 32;
    localparam int W64 = DATA_W;

    logic [DATA_W-1:0] eff_count;
    logic [DATA_W-1:0] r16, r32, r64;
    shift_req_t        req;
    shift_rsp_t        rsp;

    pk_count_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_cnt (
        .count_i     (count_i),
        .imm_i       (imm_i),
        .use_imm_i   (use_imm_i),
        .eff_count_o (eff_count)
    );

    always_comb begin
        req.data  = data_i;
        req.count = eff_count;
        req.op    = shift_op_e'(op_i);
        req.size  = lane_sz_e'(size_i);
    end

    pk_lane_shift #(.DATA_W(DATA_W), .LANE_W(W16)) u_w16 (
        .data_i(req.data), .count_i(req.count), .op_i(req.op), .res_o(r16));
    pk_lane_shift #(.DATA_W(DATA_W), .LANE_W(W32)) u_w32 (
        .data_i(req.data), .count_i(req.count), .op_i(req.op), .res_o(r32));
    pk_lane_shift #(.DATA_W(DATA_W), .LANE_W(W64)) u_w64 (
        .data_i(req.data), .count_i(req.count), .op_i(req.op), .res_o(r64));

    pk_shift_select #(.DATA_W(DATA_W)) u_sel (
        .req_i(req), .r16_i(r16), .r32_i(r32), .r64_i(r64), .rsp_o(rsp));

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                result_o  <= '0;
                illegal_o <= 1'b0;
            end else begin
                result_o  <= rsp.result;
                illegal_o <= rsp.illegal;
            end
        end

        // R11: a zero effective count on a legal request leaves the operand as it was
        a_r11_zero_count: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(eff_count) == '0 && !illegal_o) |-> result_o == $past(data_i));

        // R4: a logical shift past the 64-bit lane width always gives zero
        a_r4_logic_over: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(op_i) != 2'b10 && !illegal_o && $past(eff_count) > 64'd63)
            |-> result_o == '0);

        // R10: a rejected request passes the operand through
        a_r10_pass_through: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && illegal_o) |-> result_o == $past(data_i));

        // R10: arithmetic shift on the 64-bit lane is always flagged
        a_r10_quad_arith: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(op_i) == 2'b10 && $past(size_i) == 2'b10) |-> illegal_o);

        // R6: over-range arithmetic shift on word lanes leaves only sign copies
        a_r6_sign_fill: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(op_i) == 2'b10 && $past(size_i) == 2'b00 && $past(eff_count) > 64'd15)
            |-> result_o == {{16{$past(data_i[63])}}, {16{$past(data_i[47])}},
                             {16{$past(data_i[31])}}, {16{$past(data_i[15])}}});
    end else begin : g_comb
        assign result_o  = rsp.result;
        assign illegal_o = rsp.illegal;
    end

endmodule

// File: tb/pk_shift_unit_test.sv
module pk_shift_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] data_i = '0, count_i = '0;
    logic [7:0]  imm_i = '0;
    logic        use_imm_i = 1'b0;
    logic [1:0]  op_i = '0, size_i = '0;
    logic [63:0] result_o;
    logic        illegal_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [63:0] res;
        logic        ill;
        string       tag;
    } exp_t;

    exp_t q[$];

    always #4 clk = ~clk;

    pk_shift_unit uut (
        .clk(clk), .rst(rst), .data_i(data_i), .count_i(count_i), .imm_i(imm_i),
        .use_imm_i(use_imm_i), .op_i(op_i), .size_i(size_i),
        .result_o(result_o), .illegal_o(illegal_o)
    );

    // Bit-level reference built from the requirements.
    function automatic exp_t model(input logic [63:0] d, input logic [63:0] c,
                                   input logic [7:0] im, input logic ui,
                                   input logic [1:0] op, input logic [1:0] sz);
        exp_t e;
        logic [63:0] cnt;
        int w, amt, k;
        cnt   = ui ? {56'd0, im} : c;
        e.res = '0;
        e.ill = 1'b0;
        if (op == 2'b11 || sz == 2'b11 || (op == 2'b10 && sz == 2'b10)) begin
            e.res = d;
            e.ill = 1'b1;
            return e;
        end
        w   = (sz == 2'b00) ? 16 : (sz == 2'b01) ? 32 : 64;
        amt = (cnt < 64'(w)) ? int'(cnt) : w;
        for (int l = 0; l < 64 / w; l++) begin
            for (int b = 0; b < w; b++) begin
                if (op == 2'b00) begin
                    if (amt < w && b >= amt) e.res[l*w+b] = d[l*w+b-amt];
                end else if (op == 2'b01) begin
                    if (amt < w && b + amt < w) e.res[l*w+b] = d[l*w+b+amt];
                end else begin
                    k = b + amt;
                    if (k > w - 1) k = w - 1;
                    e.res[l*w+b] = d[l*w+k];
                end
            end
        end
        return e;
    endfunction

    task automatic drive(input logic [63:0] d, input logic [63:0] c, input logic [7:0] im,
                         input logic ui, input logic [1:0] op, input logic [1:0] sz,
                         input string tag);
        exp_t e;
        @(negedge clk);
        data_i = d; count_i = c; imm_i = im; use_imm_i = ui; op_i = op; size_i = sz;
        e = model(d, c, im, ui, op, sz);
        e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: one cycle of latency through the output register.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (result_o !== e.res || illegal_o !== e.ill) begin
                    fails++;
                    $display("FAIL %s: got res=%h ill=%b, expected res=%h ill=%b",
                             e.tag, result_o, illegal_o, e.res, e.ill);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    localparam logic [63:0] PAT = 64'h8001_C003_7FFE_4005;

    initial begin
        data_i = 64'hFFFF_FFFF_FFFF_FFFF;
        op_i = 2'b00; size_i = 2'b10; count_i = 64'd1;
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (result_o !== '0 || illegal_o !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: got res=%h ill=%b, expected res=0 ill=0", result_o, illegal_o);
        end
        @(negedge clk);
        rst = 1'b0;

        // Main function under several patterns
        drive(PAT, 64'd4, 8'd0, 1'b0, 2'b00, 2'b00, "R2 word left 4");
        drive(PAT, 64'd8, 8'd0, 1'b0, 2'b01, 2'b01, "R3 dword right 8");
        drive(PAT, 64'd12, 8'd0, 1'b0, 2'b00, 2'b10, "R12 quad left crosses lanes");
        drive(PAT, 64'd20, 8'd0, 1'b0, 2'b01, 2'b10, "R12 quad right crosses lanes");
        drive(PAT, 64'd1, 8'd0, 1'b0, 2'b00, 2'b00, "R12 word left no carry between lanes");
        drive(PAT, 64'd1, 8'd0, 1'b0, 2'b01, 2'b01, "R12 dword right no carry between lanes");
        drive(PAT, 64'd3, 8'd0, 1'b0, 2'b10, 2'b00, "R5 word arith right 3");
        drive(PAT, 64'd9, 8'd0, 1'b0, 2'b10, 2'b01, "R5 dword arith right 9");
        drive(PAT, 64'd15, 8'd0, 1'b0, 2'b10, 2'b00, "R5 word arith right 15");
        drive(PAT, 64'd1, 8'd0, 1'b0, 2'b00, 2'b01, "R9 size 01 is 32-bit lanes");

        // Range boundaries
        drive(PAT, 64'd15, 8'd0, 1'b0, 2'b00, 2'b00, "R4 word left 15 in range");
        drive(PAT, 64'd16, 8'd0, 1'b0, 2'b00, 2'b00, "R4 word left 16 zero");
        drive(PAT, 64'd32, 8'd0, 1'b0, 2'b01, 2'b01, "R4 dword right 32 zero");
        drive(PAT, 64'd63, 8'd0, 1'b0, 2'b00, 2'b10, "R4 quad left 63 in range");
        drive(PAT, 64'd64, 8'd0, 1'b0, 2'b01, 2'b10, "R4 quad right 64 zero");
        drive(PAT, 64'd16, 8'd0, 1'b0, 2'b10, 2'b00, "R6 word arith 16 sign fill");
        drive(PAT, 64'd200, 8'd0, 1'b0, 2'b10, 2'b01, "R6 dword arith 200 sign fill");

        // Full-width count comparison
        drive(PAT, 64'h1_0000_0001, 8'd0, 1'b0, 2'b00, 2'b00, "R7 high count bit word left");
        drive(PAT, 64'h8000_0000_0000_0002, 8'd0, 1'b0, 2'b10, 2'b00, "R7 high count bit arith");
        drive(PAT, 64'h0000_0100_0000_0000, 8'd0, 1'b0, 2'b01, 2'b10, "R7 high count bit quad");

        // Immediate path
        drive(PAT, 64'd1, 8'd200, 1'b1, 2'b00, 2'b10, "R8 imm 200 zeroes");
        drive(PAT, 64'hFFFF_0000_0000_0000, 8'd5, 1'b1, 2'b01, 2'b00, "R8 imm 5 count ignored");
        drive(PAT, 64'd0, 8'd17, 1'b1, 2'b10, 2'b00, "R8 imm 17 arith fill");

        // Illegal combinations
        drive(PAT, 64'd4, 8'd0, 1'b0, 2'b10, 2'b10, "R10 arith quad illegal");
        drive(PAT, 64'd4, 8'd0, 1'b0, 2'b11, 2'b00, "R10 reserved op");
        drive(PAT, 64'd4, 8'd0, 1'b0, 2'b00, 2'b11, "R10 reserved size");

        // Zero count on every legal combination
        for (int o = 0; o < 3; o++) begin
            for (int s = 0; s < 3; s++) begin
                if (!(o == 2 && s == 2))
                    drive(PAT, 64'd0, 8'd0, 1'b0, 2'(o), 2'(s), "R11 zero count unchanged");
            end
        end

        // Random patterns
        for (int n = 0; n < 300; n++) begin
            logic [63:0] rd, rc;
            rd = {$urandom(), $urandom()};
            rc = ($urandom_range(0, 3) == 0) ? {$urandom(), $urandom()} : 64'($urandom_range(0, 70));
            drive(rd, rc, 8'($urandom()), 1'($urandom()), 2'($urandom_range(0, 3)),
                  2'($urandom_range(0, 3)), "R9 random mix");
        end

        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule